// File: doc/BRIEF.md
# Bit Read-Modify-Write Unit

This block carries out single-bit and byte-field commands against a word-organised memory that is addressed bit by bit. A command names a target bit and, for the logical forms, a second source bit. The unit fetches each word it needs through a synchronous single-port memory interface. It merges the result into the target word and writes the whole word back. It also evaluates the bit conditions used by conditional branches and reports whether the branch is taken. The unit does not compute branch targets.

A bit address is 12 bits wide. Bits [11:4] pick the 16-bit word and bits [3:0] pick the bit inside it. The memory returns a defined-bits mask alongside each word, on `mem_rdef`. A bit position whose mask bit is 0 is undefined. It reads as 0, and every write-back keeps its stored value.

Commands enter on a valid/ready port. `cmd_valid` together with all command fields must stay stable until `cmd_ready` is seen high at a clock edge; that edge is the acceptance. `cmd_ready` is low for as long as a command is in flight. It returns high in the cycle after the `op_done` pulse, so only one command is processed at a time. The memory port has no handshake: a read issued in one cycle returns data on `mem_rdata`/`mem_rdef` in the next cycle, and that data is held until the next read.

Top module: `bitrmw_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `cmd_ready` is 1 and `op_done`, `jump_taken`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: A command is accepted only on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 from the cycle after acceptance through the `op_done` cycle, and it is 1 again in the following cycle. Commands presented while the unit is busy have no effect.
- R3: `op_done` is high for exactly one cycle. It rises 2 cycles after acceptance, or 3 cycles after acceptance for a two-operand command whose source and target bits lie in different words. Each read cycle is one cycle with `mem_rd_en` high, and no read cycle coincides with a write or with `op_done`.
- R4: Operation codes 0 (set), 1 (clear), 2 (copy source) and 3 (copy inverted source) write 1, 0, the source bit, or the inverted source bit into the target bit.
- R5: Codes 4, 5 and 6 write the AND, OR or XOR of the target bit and the source bit into the target bit.
- R6: When source and target lie in the same word, that word is read once and the result is computed from that single read.
- R7: Code 7 updates the low byte of the target word and code 8 updates the high byte. Each bit `i` of that byte whose `cmd_mask[i]` is 1 takes the value of `cmd_data[i]`. The bit-position part of the address is ignored.
- R8: Codes 9 and 10 report taken when the target bit is 1 or 0 respectively, and they never write.
- R9: Code 11 is taken when the bit is 1 and then clears it. Code 12 is taken when the bit is 0 and then sets it. When the jump is not taken, neither code writes.
- R10: An undefined bit used as an operand reads as 0. Every write-back carries that bit's previously read value unchanged.
- R11: A write goes to the target word, in the `op_done` cycle, at most once per command. It carries all 16 bits, and every bit the command does not address keeps the value that was read.
- R12: Codes 13 to 15 complete with the normal 2-cycle timing, with no write and with `jump_taken` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command accepted on this edge if valid |
| cmd_op | input | 4 | Operation code (see R4 to R12) |
| cmd_dst | input | 12 | Target bit address (word in [11:4], bit in [3:0]) |
| cmd_src | input | 12 | Source bit address for codes 2 to 6 |
| cmd_mask | input | 8 | Byte-field select mask for codes 7 and 8 |
| cmd_data | input | 8 | Byte-field value for codes 7 and 8 |
| mem_addr | output | 8 | Word address for read or write |
| mem_rd_en | output | 1 | Read strobe; data returns next cycle |
| mem_wr_en | output | 1 | Write strobe |
| mem_wdata | output | 16 | Whole word to write |
| mem_rdata | input | 16 | Word returned by the last read |
| mem_rdef | input | 16 | Defined-bits mask of the word returned by the last read |
| op_done | output | 1 | One-cycle completion pulse |
| jump_taken | output | 1 | Branch condition result, valid with op_done |

## Verification
The bench goes after two-operand commands with operands in the same word and in different words. A unit that mixed these up would read the wrong number of times, finish on the wrong cycle, or take the source bit from stale data. Undefined bits are used as operands, as targets and inside byte fields; an error there shows up as set bits in the read-back word or as a wrongly taken test-and-set jump. Test-and-modify jumps are issued twice on the same bit, so a unit that wrote on the untaken path would corrupt the word. A decoy command is held on the port while the unit is busy, so a handshake that accepted it would alter a word no other command touches.

// File: rtl/bitrmw_pkg.sv
package bitrmw_pkg;

  typedef enum logic [3:0] {
    OP_SET  = 4'd0,
    OP_CLR  = 4'd1,
    OP_CPY  = 4'd2,
    OP_CPYN = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_FLO  = 4'd7,
    OP_FHI  = 4'd8,
    OP_JS   = 4'd9,
    OP_JC   = 4'd10,
    OP_JSC  = 4'd11,
    OP_JCS  = 4'd12
  } bit_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RDSRC,
    ST_RDDST,
    ST_WR
  } seq_st_e;

  // Commands that take a second bit operand from the source address.
  function automatic logic uses_src(logic [3:0] op);
    return (op >= 4'(OP_CPY)) && (op <= 4'(OP_XOR));
  endfunction

endpackage

// File: rtl/bitrmw_seq.sv
module bitrmw_seq
  import bitrmw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic split,
  output logic cmd_ready,
  output logic rd_src,
  output logic rd_dst,
  output logic wr_phase
);

  seq_st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (cmd_valid) st_q <= split ? ST_RDSRC : ST_RDDST;
        ST_RDSRC: st_q <= ST_RDDST;
        ST_RDDST: st_q <= ST_WR;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st_q == ST_IDLE);
  assign rd_src    = (st_q == ST_RDSRC);
  assign rd_dst    = (st_q == ST_RDDST);
  assign wr_phase  = (st_q == ST_WR);

endmodule

// File: rtl/bitrmw_merge.sv
module bitrmw_merge
  import bitrmw_pkg::*;
#(
  parameter  int WORD_W  = 16,
  localparam int POS_W   = $clog2(WORD_W),
  localparam int FIELD_W = WORD_W / 2
) (
  input  logic [3:0]         op,
  input  logic [POS_W-1:0]   dpos,
  input  logic               sbit,
  input  logic [WORD_W-1:0]  rdata,
  input  logic [WORD_W-1:0]  rdef,
  input  logic [FIELD_W-1:0] fmask,
  input  logic [FIELD_W-1:0] fdata,
  output logic [WORD_W-1:0]  wdata,
  output logic               wr_need,
  output logic               taken
);

  logic [WORD_W-1:0] one_hot;
  logic [WORD_W-1:0] sel;
  logic [WORD_W-1:0] val;
  logic              dbit;

  assign one_hot = WORD_W'(1) << dpos;
  assign dbit    = rdata[dpos] & rdef[dpos];

  always_comb begin
    sel     = '0;
    val     = '0;
    wr_need = 1'b0;
    taken   = 1'b0;
    case (op)
      OP_SET:  begin sel = one_hot; val = '1;                     wr_need = 1'b1; end
      OP_CLR:  begin sel = one_hot; val = '0;                     wr_need = 1'b1; end
      OP_CPY:  begin sel = one_hot; val = {WORD_W{sbit}};         wr_need = 1'b1; end
      OP_CPYN: begin sel = one_hot; val = {WORD_W{~sbit}};        wr_need = 1'b1; end
      OP_AND:  begin sel = one_hot; val = {WORD_W{dbit & sbit}};  wr_need = 1'b1; end
      OP_OR:   begin sel = one_hot; val = {WORD_W{dbit | sbit}};  wr_need = 1'b1; end
      OP_XOR:  begin sel = one_hot; val = {WORD_W{dbit ^ sbit}};  wr_need = 1'b1; end
      OP_FLO: begin
        sel = {{FIELD_W{1'b0}}, fmask};
        val = {{FIELD_W{1'b0}}, fdata};
        wr_need = 1'b1;
      end
      OP_FHI: begin
        sel = {fmask, {FIELD_W{1'b0}}};
        val = {fdata, {FIELD_W{1'b0}}};
        wr_need = 1'b1;
      end
      OP_JS:  taken = dbit;
      OP_JC:  taken = ~dbit;
      OP_JSC: begin taken = dbit;  sel = one_hot; val = '0; wr_need = dbit;  end
      OP_JCS: begin taken = ~dbit; sel = one_hot; val = '1; wr_need = ~dbit; end
      default: ;
    endcase
  end

  // Undefined positions always carry the read value back.
  assign wdata = (rdata & ~(sel & rdef)) | (val & sel & rdef);

endmodule

// File: rtl/bitrmw_unit.sv
module bitrmw_unit
  import bitrmw_pkg::*;
#(
  parameter  int ADDR_W  = 12,
  parameter  int WORD_W  = 16,
  localparam int POS_W   = $clog2(WORD_W),
  localparam int WADDR_W = ADDR_W - POS_W,
  localparam int FIELD_W = WORD_W / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [3:0]         cmd_op,
  input  logic [ADDR_W-1:0]  cmd_dst,
  input  logic [ADDR_W-1:0]  cmd_src,
  input  logic [FIELD_W-1:0] cmd_mask,
  input  logic [FIELD_W-1:0] cmd_data,
  output logic [WADDR_W-1:0] mem_addr,
  output logic               mem_rd_en,
  output logic               mem_wr_en,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic [WORD_W-1:0]  mem_rdata,
  input  logic [WORD_W-1:0]  mem_rdef,
  output logic               op_done,
  output logic               jump_taken
);

  logic               fire, split_in;
  logic               rd_src, rd_dst, wr_phase;
  logic [3:0]         op_q;
  logic [ADDR_W-1:0]  dst_q, src_q;
  logic [FIELD_W-1:0] mask_q, data_q;
  logic               split_q, srcbit_q;
  logic               sbit_now, wr_need, taken;
  logic [POS_W-1:0]   spos;

  assign fire     = cmd_valid & cmd_ready;
  assign split_in = uses_src(cmd_op) &&
                    (cmd_dst[ADDR_W-1:POS_W] != cmd_src[ADDR_W-1:POS_W]);
  assign spos     = src_q[POS_W-1:0];

  bitrmw_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .split     (split_in),
    .cmd_ready (cmd_ready),
    .rd_src    (rd_src),
    .rd_dst    (rd_dst),
    .wr_phase  (wr_phase)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q     <= '0;
      dst_q    <= '0;
      src_q    <= '0;
      mask_q   <= '0;
      data_q   <= '0;
      split_q  <= 1'b0;
      srcbit_q <= 1'b0;
    end else begin
      if (fire) begin
        op_q    <= cmd_op;
        dst_q   <= cmd_dst;
        src_q   <= cmd_src;
        mask_q  <= cmd_mask;
        data_q  <= cmd_data;
        split_q <= split_in;
      end
      // During the target read, the source word returned from the previous cycle.
      if (rd_dst) srcbit_q <= mem_rdata[spos] & mem_rdef[spos];
    end
  end

  assign sbit_now = split_q ? srcbit_q : (mem_rdata[spos] & mem_rdef[spos]);

  bitrmw_merge #(.WORD_W(WORD_W)) u_merge (
    .op      (op_q),
    .dpos    (dst_q[POS_W-1:0]),
    .sbit    (sbit_now),
    .rdata   (mem_rdata),
    .rdef    (mem_rdef),
    .fmask   (mask_q),
    .fdata   (data_q),
    .wdata   (mem_wdata),
    .wr_need (wr_need),
    .taken   (taken)
  );

  assign mem_addr   = rd_src ? src_q[ADDR_W-1:POS_W] : dst_q[ADDR_W-1:POS_W];
  assign mem_rd_en  = rd_src | rd_dst;
  assign mem_wr_en  = wr_phase & wr_need;
  assign op_done    = wr_phase;
  assign jump_taken = wr_phase & taken;

endmodule

// File: rtl/bitrmw_chk.sv
module bitrmw_chk
  import bitrmw_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [3:0]        cmd_op,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [WORD_W-1:0] mem_wdata,
  input logic [WORD_W-1:0] mem_rdata,
  input logic [WORD_W-1:0] mem_rdef,
  input logic              op_done,
  input logic              jump_taken
);

  logic [3:0] seen_op;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_op <= '0;
    else if (cmd_valid && cmd_ready) seen_op <= cmd_op;
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R2
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> (cmd_ready && !op_done));

  // R3
  read_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (!mem_wr_en && !op_done));

  // R11
  write_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> op_done);

  // R10
  undef_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (((mem_wdata ^ mem_rdata) & ~mem_rdef) == '0));

  // R8
  plain_test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && (seen_op == OP_JS || seen_op == OP_JC)) |-> !mem_wr_en);

  // R9
  untaken_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && (seen_op == OP_JSC || seen_op == OP_JCS) && !jump_taken) |-> !mem_wr_en);

  // R12
  reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && seen_op > 4'(OP_JCS)) |-> (!mem_wr_en && !jump_taken));

  // R8
  taken_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_taken |-> op_done);

endmodule

bind bitrmw_unit bitrmw_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_op     (cmd_op),
  .mem_rd_en  (mem_rd_en),
  .mem_wr_en  (mem_wr_en),
  .mem_wdata  (mem_wdata),
  .mem_rdata  (mem_rdata),
  .mem_rdef   (mem_rdef),
  .op_done    (op_done),
  .jump_taken (jump_taken)
);

// File: tb/test_bitrmw_unit.sv
`timescale 1ns/1ps
module test_bitrmw_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [11:0] cmd_dst = '0, cmd_src = '0;
  logic [7:0]  cmd_mask = '0, cmd_data = '0;
  logic [7:0]  mem_addr;
  logic        mem_rd_en, mem_wr_en;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0, mem_rdef = '0;
  logic        op_done, jump_taken;

  logic [15:0] mem [256];
  logic [15:0] exp_mem [256];
  logic [15:0] defm [256];
  int tests = 0, fails = 0, rd_cnt = 0;

  always #2 clk = ~clk;

  bitrmw_unit i_bitrmw_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dst(cmd_dst), .cmd_src(cmd_src), .cmd_mask(cmd_mask),
    .cmd_data(cmd_data), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rdef(mem_rdef), .op_done(op_done), .jump_taken(jump_taken)
  );

  // Memory model: one-cycle read latency, data held until the next read.
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mem[mem_addr];
      mem_rdef  <= defm[mem_addr];
      rd_cnt    <= rd_cnt + 1;
    end
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] put(logic [15:0] w, logic [15:0] dm, int p, logic v);
    if (dm[p]) w[p] = v;
    return w;
  endfunction

  task automatic run_cmd(input logic [3:0] op, input logic [11:0] d, input logic [11:0] s,
                         input logic [7:0] m, input logic [7:0] dt, input string req);
    int dw = int'(d[11:4]);
    int dp = int'(d[3:0]);
    int sw = int'(s[11:4]);
    int sp = int'(s[3:0]);
    logic dbit = exp_mem[dw][dp] & defm[dw][dp];
    logic sbit = exp_mem[sw][sp] & defm[sw][sp];
    logic [15:0] w = exp_mem[dw];
    logic tk = 1'b0;
    int lat;
    case (op)
      4'd0: w = put(w, defm[dw], dp, 1'b1);
      4'd1: w = put(w, defm[dw], dp, 1'b0);
      4'd2: w = put(w, defm[dw], dp, sbit);
      4'd3: w = put(w, defm[dw], dp, !sbit);
      4'd4: w = put(w, defm[dw], dp, dbit & sbit);
      4'd5: w = put(w, defm[dw], dp, dbit | sbit);
      4'd6: w = put(w, defm[dw], dp, dbit ^ sbit);
      4'd7: for (int i = 0; i < 8; i++) if (m[i]) w = put(w, defm[dw], i, dt[i]);
      4'd8: for (int i = 0; i < 8; i++) if (m[i]) w = put(w, defm[dw], i + 8, dt[i]);
      4'd9:  tk = dbit;
      4'd10: tk = !dbit;
      4'd11: begin tk = dbit;  if (tk) w = put(w, defm[dw], dp, 1'b0); end
      4'd12: begin tk = !dbit; if (tk) w = put(w, defm[dw], dp, 1'b1); end
      default: ;
    endcase
    lat = (op >= 4'd2 && op <= 4'd6 && sw != dw) ? 3 : 2;

    @(negedge clk);
    cmd_op = op; cmd_dst = d; cmd_src = s; cmd_mask = m; cmd_data = dt;
    cmd_valid = 1'b1;
    chk(cmd_ready === 1'b1, "R2", "ready before accept", 16'(cmd_ready), 16'h1);
    @(posedge clk);
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      if (k == 1) begin
        rd_cnt = 0;
        // Decoy held on the port while busy: must never be taken (R2).
        cmd_op = 4'd0; cmd_dst = 12'hFF0;
      end
      chk(cmd_ready === 1'b0, "R2", "ready while busy", 16'(cmd_ready), 16'h0);
      chk(op_done === (k == lat), "R3", "done timing", 16'(op_done), 16'(k == lat));
      if (k == lat) begin
        chk(jump_taken === tk, req, "jump result", 16'(jump_taken), 16'(tk));
        chk(rd_cnt == lat - 1, "R6", "read count", 16'(rd_cnt), 16'(lat - 1));
        cmd_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(cmd_ready === 1'b1 && op_done === 1'b0, "R2", "idle after done",
        16'({cmd_ready, op_done}), 16'h2);
    chk(mem[dw] === w, req, "target word", mem[dw], w);
    chk(mem[255] === exp_mem[255], "R2", "decoy word untouched", mem[255], exp_mem[255]);
    if (sw != dw)
      chk(mem[sw] === exp_mem[sw], "R11", "source word untouched", mem[sw], exp_mem[sw]);
    exp_mem[dw] = w;
  endtask

  task automatic main();
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 16'(i * 40503 + 12345);
      defm[i] = (i % 4 == 3) ? 16'h0FF0 : 16'hFFFF;
    end
    mem[255] = 16'h1234;
    defm[255] = 16'hFFFF;
    for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];

    repeat (3) @(negedge clk);
    chk(cmd_ready === 1'b1 && op_done === 1'b0 && jump_taken === 1'b0 &&
        mem_rd_en === 1'b0 && mem_wr_en === 1'b0, "R1", "in reset",
        16'({cmd_ready, op_done, jump_taken, mem_rd_en, mem_wr_en}), 16'h10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready === 1'b1 && op_done === 1'b0 && mem_rd_en === 1'b0 && mem_wr_en === 1'b0,
        "R1", "after reset", 16'({cmd_ready, op_done, mem_rd_en, mem_wr_en}), 16'h8);

    run_cmd(4'd0, {8'h10, 4'd5}, 12'h0, 8'h0, 8'h0, "R4");
    run_cmd(4'd1, {8'h10, 4'd6}, 12'h0, 8'h0, 8'h0, "R4");
    run_cmd(4'd2, {8'h11, 4'd2}, {8'h14, 4'd9}, 8'h0, 8'h0, "R4");
    run_cmd(4'd3, {8'h11, 4'd3}, {8'h11, 4'd2}, 8'h0, 8'h0, "R6");
    run_cmd(4'd4, {8'h12, 4'd0}, {8'h15, 4'd7}, 8'h0, 8'h0, "R5");
    run_cmd(4'd5, {8'h12, 4'd1}, {8'h15, 4'd8}, 8'h0, 8'h0, "R5");
    run_cmd(4'd6, {8'h12, 4'd2}, {8'h12, 4'd0}, 8'h0, 8'h0, "R6");
    run_cmd(4'd6, {8'h12, 4'd3}, {8'h03, 4'd0}, 8'h0, 8'h0, "R10");
    run_cmd(4'd3, {8'h12, 4'd4}, {8'h03, 4'd15}, 8'h0, 8'h0, "R10");
    run_cmd(4'd7, {8'h16, 4'd9}, 12'h0, 8'hA5, 8'h3C, "R7");
    run_cmd(4'd8, {8'h16, 4'd0}, 12'h0, 8'hF0, 8'h9F, "R7");
    run_cmd(4'd8, {8'h03, 4'd0}, 12'h0, 8'hFF, 8'hFF, "R10");
    run_cmd(4'd7, {8'h03, 4'd0}, 12'h0, 8'hFF, 8'h00, "R10");
    run_cmd(4'd0, {8'h07, 4'd1}, 12'h0, 8'h0, 8'h0, "R10");
    run_cmd(4'd9, {8'h07, 4'd14}, 12'h0, 8'h0, 8'h0, "R10");
    run_cmd(4'd12, {8'h07, 4'd14}, 12'h0, 8'h0, 8'h0, "R10");
    run_cmd(4'd9, {8'h10, 4'd5}, 12'h0, 8'h0, 8'h0, "R8");
    run_cmd(4'd10, {8'h10, 4'd5}, 12'h0, 8'h0, 8'h0, "R8");
    run_cmd(4'd9, {8'h10, 4'd6}, 12'h0, 8'h0, 8'h0, "R8");
    run_cmd(4'd10, {8'h10, 4'd6}, 12'h0, 8'h0, 8'h0, "R8");
    run_cmd(4'd11, {8'h10, 4'd5}, 12'h0, 8'h0, 8'h0, "R9");
    run_cmd(4'd11, {8'h10, 4'd5}, 12'h0, 8'h0, 8'h0, "R9");
    run_cmd(4'd12, {8'h10, 4'd6}, 12'h0, 8'h0, 8'h0, "R9");
    run_cmd(4'd12, {8'h10, 4'd6}, 12'h0, 8'h0, 8'h0, "R9");
    run_cmd(4'd13, {8'h10, 4'd6}, 12'h0, 8'hFF, 8'hFF, "R12");
    run_cmd(4'd15, {8'h10, 4'd5}, 12'h0, 8'hFF, 8'h00, "R12");
    for (int i = 0; i < 32; i++)
      run_cmd(4'(i % 9), 12'(16'h200 + i * 37), 12'(16'h300 + i * 53), 8'(i * 29), 8'(i * 71), "R11");
  endtask

  initial begin
    fork
      main();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R3 watchdog: actual %0d expected 0", 1);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule